// File: doc/BRIEF.md
# Dual-Source SPI Frame Serializer

This block is a 16-bit SPI master whose single shift engine is shared by two word sources. The first source is a host queue: the block reads it through a FIFO-style port, with a not-empty flag, the head word and a pop pulse. The second source is a bank of parallel input pins. The block samples these pins on every system clock and streams them out serially whenever the host queue has nothing to send.

An arbiter decides the source at each frame boundary. A waiting host word always wins over pin data. A frame that has already started is never cut short. Each source has its own active-low chip select. The word shifted in during a frame goes to the receive side of its own source. Host frames push their word into a receive FIFO port. Pin frames latch their word into a register that drives the parallel output pins. The block also keeps a copy of the last pin word it sent, so that the surrounding logic can compare against it.

The serial side runs in mode 0 with the most significant bit first. SCK is the system clock divided by the even parameter `DIV`, and it idles low.

Top module: `dual_source_spi`

## Requirements
- R1: `pin_in` is sampled on every clock. A pin frame carries the value the pins held two clock edges before its chip select falls (the last sample before the start edge). A pin change made after a frame has started is carried by the next pin frame.
- R2: A frame starts only from idle. If `tx_valid` is high at the start edge, the frame takes the host word `tx_data`. Otherwise a pin frame starts only when `pin_en` is high. A frame in progress always completes all 16 bits, and a host word that arrives meanwhile goes out in the next frame.
- R3: When a pin frame starts, `pin_last` takes the word that frame transmits, and it keeps that value until the next pin frame starts.
- R4: `cs_host_n` is low only during host frames and `cs_pin_n` is low only during pin frames. The two are never low together.
- R5: At the end of a pin frame, the 16-bit word received on `sin` appears on `pin_out` in the same cycle as `cs_pin_n` rises. `rx_push` stays low for pin frames.
- R6: At the end of a host frame, `rx_push` pulses for one cycle with the received word on `rx_data`, in the same cycle as `cs_host_n` rises. `pin_out` is left unchanged by host frames.
- R7: A frame is 16 SCK cycles. `sout` presents the MSB first and changes only while SCK falls. `sin` is sampled as SCK rises, and the first sampled bit becomes the MSB. Each SCK level lasts `DIV/2` clocks.
- R8: While no request is pending (`tx_valid` low and `pin_en` low), both chip selects stay high and `sck` stays low, whatever `pin_in` does.
- R9: The chip select falls `DIV/2` clocks before the first rising SCK edge. It rises `DIV/2` clocks after the last falling edge. At least `DIV/2` clocks pass with both selects high between frames.
- R10: If `rx_full` is high when a host frame completes, no push happens and `rx_ovf` goes high. `rx_ovf` then stays high until reset.
- R11: `tx_ack` pulses for one cycle, in the cycle after the start edge of each host frame, and at no other time.
- R12: After reset, both chip selects are high, and `sck`, `tx_ack`, `rx_push`, `rx_ovf`, `pin_out` and `pin_last` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_valid | input | 1 | Host queue holds at least one word |
| tx_data | input | W | Head word of the host queue |
| tx_ack | output | 1 | Pop pulse for the host queue head |
| rx_data | output | W | Word received in the last host frame |
| rx_push | output | 1 | Write strobe into the receive FIFO |
| rx_full | input | 1 | Receive FIFO cannot accept a word |
| rx_ovf | output | 1 | Sticky flag for a host word dropped on a full receive FIFO |
| pin_en | input | 1 | Allows pin frames while the host queue is empty |
| pin_in | input | W | Parallel input pins |
| pin_out | output | W | Word received in the last pin frame |
| pin_last | output | W | Copy of the last pin word transmitted |
| sck | output | 1 | Serial clock, idles low |
| sout | output | 1 | Serial data out |
| sin | input | 1 | Serial data in |
| cs_host_n | output | 1 | Chip select for host frames, active low |
| cs_pin_n | output | 1 | Chip select for pin frames, active low |

## Verification
The assertions assume that the host queue behaves like a FIFO. `tx_valid` and `tx_data` change only after a pop or a push. The assertions also assume that `rx_full` is a level that stays constant for the length of a frame, and that `DIV` is even and at least 4. The stimulus applies every input change on the falling clock edge. It changes `rx_full` only while the block is idle. It changes `pin_in` either at a frame's end or deep inside a frame, so a change never lands within a clock of a start edge. This keeps the expected pin word unambiguous.

// File: rtl/dss_pkg.sv
package dss_pkg;

  typedef enum logic {SRC_HOST = 1'b0, SRC_PIN = 1'b1} src_e;

  // A frame spends one lead half, 2*w shifting halves and one gap half.
  function automatic int halves_per_frame(input int w);
    return 2 * w + 2;
  endfunction

  // Index of the gap half, the one where both selects are released.
  function automatic int gap_half(input int w);
    return 2 * w + 1;
  endfunction

endpackage

// File: rtl/dss_pacer.sv
module dss_pacer #(
  parameter int HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] TOP = CW'(HALF - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt <= '0;
    else if (!run || cnt == TOP) cnt <= '0;
    else                         cnt <= cnt + 1'b1;
  end

  assign tick = run && (cnt == TOP);
endmodule

// File: rtl/dss_sequencer.sv
module dss_sequencer
  import dss_pkg::*;
#(
  parameter int W = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic tick,
  output logic busy,
  output logic sck,
  output logic cs_on,
  output logic rise_evt,
  output logic fall_evt,
  output logic done_evt
);
  localparam int NH = halves_per_frame(W);
  localparam int HW = $clog2(NH);
  localparam logic [HW-1:0] LAST = HW'(gap_half(W));

  logic [HW-1:0] hc;
  logic [HW-1:0] nxt;

  assign nxt      = hc + 1'b1;
  // odd halves are SCK-high, except the gap half
  assign rise_evt = busy && tick && nxt[0] && (nxt != LAST);
  assign fall_evt = busy && tick && !nxt[0] && (hc != LAST);
  assign done_evt = busy && tick && (nxt == LAST);
  assign cs_on    = busy && (hc != LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      hc   <= '0;
      sck  <= 1'b0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        hc   <= '0;
      end
    end else if (tick) begin
      if (hc == LAST) busy <= 1'b0;
      else            hc   <= nxt;
      sck <= rise_evt;
    end
  end
endmodule

// File: rtl/dss_shifter.sv
module dss_shifter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_word,
  input  logic         shift,
  input  logic         sample,
  input  logic         sin,
  output logic         sout,
  output logic [W-1:0] rx_word
);
  logic [W-1:0] tx_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh   <= '0;
      rx_word <= '0;
    end else begin
      if (load)        tx_sh <= load_word;
      else if (shift)  tx_sh <= {tx_sh[W-2:0], 1'b0};
      if (sample)      rx_word <= {rx_word[W-2:0], sin};
    end
  end

  assign sout = tx_sh[W-1];
endmodule

// File: rtl/dual_source_spi.sv
module dual_source_spi
  import dss_pkg::*;
#(
  parameter int W   = 16,
  parameter int DIV = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tx_valid,
  input  logic [W-1:0] tx_data,
  output logic         tx_ack,
  output logic [W-1:0] rx_data,
  output logic         rx_push,
  input  logic         rx_full,
  output logic         rx_ovf,
  input  logic         pin_en,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] pin_out,
  output logic [W-1:0] pin_last,
  output logic         sck,
  output logic         sout,
  input  logic         sin,
  output logic         cs_host_n,
  output logic         cs_pin_n
);
  localparam int HALF = DIV / 2;

  logic [W-1:0] pin_q;
  logic [W-1:0] rx_word;
  logic [W-1:0] load_word;
  src_e         src;
  logic busy, tick, cs_on, rise_evt, fall_evt, done_evt;
  logic start, host_win, host_done, pin_done;

  // arbitration at the frame boundary: queued host word beats pins
  assign start     = !busy && (tx_valid || pin_en);
  assign host_win  = tx_valid;
  assign load_word = host_win ? tx_data : pin_q;
  assign host_done = done_evt && (src == SRC_HOST);
  assign pin_done  = done_evt && (src == SRC_PIN);

  dss_pacer #(.HALF(HALF)) u_pacer (
    .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick)
  );

  dss_sequencer #(.W(W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .tick(tick),
    .busy(busy), .sck(sck), .cs_on(cs_on),
    .rise_evt(rise_evt), .fall_evt(fall_evt), .done_evt(done_evt)
  );

  dss_shifter #(.W(W)) u_shift (
    .clk(clk), .rst_n(rst_n), .load(start), .load_word(load_word),
    .shift(fall_evt), .sample(rise_evt), .sin(sin),
    .sout(sout), .rx_word(rx_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= '0;
    else        pin_q <= pin_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src      <= SRC_HOST;
      tx_ack   <= 1'b0;
      pin_last <= '0;
    end else begin
      tx_ack <= start && host_win;
      if (start) begin
        src <= host_win ? SRC_HOST : SRC_PIN;
        if (!host_win) pin_last <= pin_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_push <= 1'b0;
      rx_data <= '0;
      rx_ovf  <= 1'b0;
      pin_out <= '0;
    end else begin
      rx_push <= host_done && !rx_full;
      if (host_done) begin
        if (rx_full) rx_ovf  <= 1'b1;
        else         rx_data <= rx_word;
      end
      if (pin_done) pin_out <= rx_word;
    end
  end

  assign cs_host_n = !(cs_on && src == SRC_HOST);
  assign cs_pin_n  = !(cs_on && src == SRC_PIN);
endmodule

// File: rtl/dss_checker.sv
module dss_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         sck,
  input logic         sout,
  input logic         cs_host_n,
  input logic         cs_pin_n,
  input logic         tx_valid,
  input logic         tx_ack,
  input logic         rx_full,
  input logic         rx_push,
  input logic         rx_ovf,
  input logic [W-1:0] pin_last,
  input logic [W-1:0] pin_q
);
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_host_n && cs_pin_n) |-> !sck);                                  // R8
  AST_PIN_AFTER_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_pin_n) |-> !$past(tx_valid));                              // R2
  AST_PIN_COPY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_pin_n) |-> pin_last == $past(pin_q));                      // R3
  AST_SOUT_HOLD_ON_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sck) |-> $stable(sout));                                      // R7
  AST_PUSH_AT_HOST_END: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> $rose(cs_host_n));                                      // R6
  AST_NO_PUSH_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push |-> !$past(rx_full));                                       // R10
  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ovf) |-> $past(rx_full));                                  // R10
  AST_ACK_WITH_HOST_CS: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ack |-> $fell(cs_host_n));                                       // R11
endmodule

bind dual_source_spi dss_checker #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .sck(sck), .sout(sout),
  .cs_host_n(cs_host_n), .cs_pin_n(cs_pin_n), .tx_valid(tx_valid),
  .tx_ack(tx_ack), .rx_full(rx_full), .rx_push(rx_push), .rx_ovf(rx_ovf),
  .pin_last(pin_last), .pin_q(pin_q)
);

// File: tb/dual_source_spi_test.sv
`timescale 1ns/1ps
module dual_source_spi_test;
  localparam int W = 16;
  localparam int DIV = 4;
  localparam int HALF = DIV / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_full = 1'b0, pin_en = 1'b0, sin = 1'b0;
  logic [W-1:0] pin_in = '0;
  logic tx_valid, tx_ack, rx_push, rx_ovf, sck, sout, cs_host_n, cs_pin_n;
  logic [W-1:0] tx_data, rx_data, pin_out, pin_last;

  logic [W-1:0] hq [0:127];
  int hq_wr = 0, hq_rd = 0;
  assign tx_valid = (hq_rd != hq_wr);
  assign tx_data  = hq[hq_rd];

  int checks = 0, errors = 0, nframes = 0, cyc = 0;
  bit fr_host [0:255];
  logic [W-1:0] fr_word [0:255];
  bit ovf_exp = 0;

  always #2.5 clk = ~clk;

  dual_source_spi #(.W(W), .DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ack(tx_ack), .rx_data(rx_data), .rx_push(rx_push), .rx_full(rx_full),
    .rx_ovf(rx_ovf), .pin_en(pin_en), .pin_in(pin_in), .pin_out(pin_out),
    .pin_last(pin_last), .sck(sck), .sout(sout), .sin(sin),
    .cs_host_n(cs_host_n), .cs_pin_n(cs_pin_n)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] mk_reply(input int n);
    logic [31:0] t;
    t = n * 12061;
    return t[W-1:0] ^ 16'hC35A;
  endfunction

  task automatic push(input logic [W-1:0] w);
    hq[hq_wr] = w;
    hq_wr++;
  endtask

  task automatic wait_frames(input int target);
    while (nframes < target) @(negedge clk);
  endtask

  // serial slave and frame monitor, all sampling on the falling clock edge
  initial begin : mon
    logic p_sck, p_ch, p_cp, cur_host, have_prev;
    logic [W-1:0] reply, got, exp_w, po_prev;
    int bitn, rises, t_fall, t_last, t_rise;
    p_sck = 0; p_ch = 1; p_cp = 1; cur_host = 0; have_prev = 0;
    reply = '0; got = '0; exp_w = '0; po_prev = '0;
    bitn = 0; rises = 0; t_fall = 0; t_last = 0; t_rise = 0;
    forever begin
      @(negedge clk);
      cyc++;
      if (!rst_n) continue;
      if ((p_ch && !cs_host_n) || (p_cp && !cs_pin_n)) begin
        cur_host = p_ch && !cs_host_n;
        chk(cs_host_n || cs_pin_n, "R4 both selects low", {cs_host_n, cs_pin_n}, 2'b01);
        if (have_prev) chk(cyc - t_rise >= HALF, "R9 idle gap", cyc - t_rise, HALF);
        reply = mk_reply(nframes);
        sin = reply[W-1];
        bitn = 0; rises = 0; got = '0; t_fall = cyc;
        exp_w = cur_host ? hq[hq_rd] : pin_in;
        po_prev = pin_out;
        chk(tx_ack == cur_host, "R11 ack at frame start", tx_ack, cur_host);
      end else if (tx_ack) begin
        chk(0, "R11 stray ack", 1, 0);
      end
      if (tx_ack) hq_rd++;
      if (!p_sck && sck) begin
        if (rises == 0) chk(cyc - t_fall == HALF, "R9 lead time", cyc - t_fall, HALF);
        got = {got[W-2:0], sout};
        rises++;
      end
      if (p_sck && !sck) begin
        t_last = cyc;
        bitn++;
        if (bitn < W) sin = reply[W-1-bitn];
      end
      if ((!p_ch && cs_host_n) || (!p_cp && cs_pin_n)) begin
        chk(cyc - t_last == HALF, "R9 trail time", cyc - t_last, HALF);
        chk(rises == W, "R7 bit count", rises, W);
        chk(got == exp_w, "R7 R1 R2 transmitted word", got, exp_w);
        if (cur_host) begin
          if (rx_full) begin
            ovf_exp = 1;
            chk(!rx_push, "R10 push on full", rx_push, 0);
          end else begin
            chk(rx_push && rx_data == reply, "R6 host receive", {rx_push, rx_data}, {1'b1, reply});
          end
          chk(rx_ovf == ovf_exp, "R10 overflow flag", rx_ovf, ovf_exp);
          chk(pin_out == po_prev, "R6 pin_out untouched", pin_out, po_prev);
        end else begin
          chk(pin_out == reply, "R5 pin receive", pin_out, reply);
          chk(!rx_push, "R5 no push", rx_push, 0);
          chk(pin_last == exp_w, "R3 comparison copy", pin_last, exp_w);
        end
        fr_host[nframes] = cur_host;
        fr_word[nframes] = got;
        nframes++;
        t_rise = cyc;
        have_prev = 1;
      end
      p_sck = sck; p_ch = cs_host_n; p_cp = cs_pin_n;
    end
  end

  initial begin : watchdog
    repeat (200000) @(negedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int bad, n0;
    repeat (3) @(negedge clk);
    chk(cs_host_n && cs_pin_n && !sck && !tx_ack && !rx_push && !rx_ovf
        && pin_out == 0 && pin_last == 0, "R12 reset state", {cs_host_n, cs_pin_n, sck}, 3'b110);
    rst_n = 1'b1;

    // R8: nothing requested, pins wiggling
    bad = 0;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      pin_in = 16'h1 << (i % W);
      if (!(cs_host_n && cs_pin_n && !sck)) bad++;
    end
    chk(bad == 0 && nframes == 0, "R8 idle quiet", bad, 0);

    // host sweep: walking ones, all zeros, all ones
    for (int i = 0; i < W; i++) push(16'h1 << i);
    push(16'h0000);
    push(16'hFFFF);
    wait_frames(W + 2);
    for (int i = 0; i < W + 2; i++) chk(fr_host[i], "R4 host select", fr_host[i], 1);

    // pin sweep: walking zeros, new value set during each gap
    pin_in = ~16'h1;
    pin_en = 1'b1;
    for (int i = 1; i <= W; i++) begin
      n0 = nframes;
      wait_frames(n0 + 1);
      chk(!fr_host[n0], "R4 pin select", fr_host[n0], 0);
      pin_in = ~(16'h1 << (i % W));
    end

    // R1: pin change deep inside a frame waits for the next frame
    @(negedge clk);
    while (cs_pin_n) @(negedge clk);
    repeat (20) @(negedge clk);
    n0 = nframes;
    bad = pin_in;
    pin_in = 16'h5AA5;
    wait_frames(n0 + 2);
    chk(fr_word[n0] == 16'(bad), "R1 word fixed at start", fr_word[n0], bad);
    chk(fr_word[n0 + 1] == 16'h5AA5, "R1 new pins next frame", fr_word[n0 + 1], 16'h5AA5);

    // R2: host word arriving mid pin frame goes next
    while (cs_pin_n) @(negedge clk);
    repeat (10) @(negedge clk);
    n0 = nframes;
    push(16'hBEEF);
    wait_frames(n0 + 3);
    chk(!fr_host[n0], "R2 running pin frame kept", fr_host[n0], 0);
    chk(fr_host[n0 + 1], "R2 host frame next", fr_host[n0 + 1], 1);
    chk(!fr_host[n0 + 2], "R2 pins resume", fr_host[n0 + 2], 0);

    // R2: queued host words all drain before a pin frame
    pin_en = 1'b0;
    repeat (90) @(negedge clk);
    n0 = nframes;
    push(16'h1234); push(16'h8421); push(16'h0F0F); push(16'hF00D);
    pin_en = 1'b1;
    wait_frames(n0 + 5);
    for (int i = 0; i < 4; i++) chk(fr_host[n0 + i], "R2 host burst", fr_host[n0 + i], 1);
    chk(!fr_host[n0 + 4], "R2 pin after burst", fr_host[n0 + 4], 0);

    // R10: host frame completing into a full receive FIFO
    pin_en = 1'b0;
    repeat (90) @(negedge clk);
    rx_full = 1'b1;
    n0 = nframes;
    push(16'hA5A5);
    wait_frames(n0 + 1);
    repeat (HALF + 2) @(negedge clk);
    rx_full = 1'b0;
    chk(rx_ovf, "R10 flag sticky", rx_ovf, 1);
    push(16'h3C3C);
    wait_frames(n0 + 2);
    repeat (5) @(negedge clk);
    chk(rx_ovf, "R10 flag kept after good push", rx_ovf, 1);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule